// File: doc/BRIEF.md
# ADC Conversion Trigger and Sample Buffer Controller

This block sits between a multichannel analog-to-digital converter and the bus that software uses to run it. One 16-bit control word picks where each start-of-conversion pulse comes from. The source can be a software strobe, a rising or a falling edge on an external line, or the rising edge of any one of three counter outputs. The same word also turns the sample buffer on, clears it, and chooses which buffer fill condition drives the interrupt line. Input range and input mode bits are stored and read back for the analog front end, but they do not change the block's own behaviour.

Each completed conversion comes back as a done strobe with a 12-bit sample. The sample is stored in a first-in first-out buffer only when a real source is selected, the buffer is enabled and there is room. Software reads samples through a show-ahead read port and polls the empty, half-full, full and busy flags in the upper bits of the control word. A full flag that stays set means samples are being lost, so software can detect an overrun.

Top module: `adc_sample_ctrl`

## Requirements
- R1: After reset the control fields are zero, the control readback is 0x1000 (only the empty flag at bit 12 set), and irq and conv_start are low.
- R2: With source field bits 2:0 = 1, a one-cycle sw_start produces a one-cycle conv_start on the next cycle.
- R3: Source 2 starts a conversion on a rising edge of ext_trig and source 3 on a falling edge; the opposite edge starts nothing.
- R4: Sources 4, 5 and 6 start a conversion on a rising edge of cnt_out bit 0, 1 and 2 respectively; edges on the other counter bits start nothing.
- R5: When the source field is 0 or 7, or when the buffer enable bit 8 is 0, no conversion starts and conv_done samples are not stored.
- R6: Busy (readback bit 15) is set from the cycle conv_start is high until conv_done arrives; start events while busy are ignored.
- R7: Readback returns the source field in bits 2:0, range in bit 3, mode in bit 4, buffer enable in bit 8 and interrupt select in bits 10:9 as written; bit 11 and bits 5 to 7 read as 0.
- R8: Stored samples come out of fifo_rdata in arrival order, the oldest is shown before it is read, and fifo_rd removes it.
- R9: Bit 12 is empty, bit 13 is full (DEPTH entries), and bit 14 is half full (DEPTH/2 or more entries); a sample that arrives while the buffer is full is dropped.
- R10: A write with bit 11 set empties the buffer by the next cycle, and the other fields of that write take effect.
- R11: irq is a level: with interrupt select 0 it follows empty, with 1 not-empty, with 2 half-full, and with 3 it stays low; it is always low while the buffer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control fields and status flags |
| sw_start | input | 1 | Software start strobe |
| ext_trig | input | 1 | External trigger line |
| cnt_out | input | 3 | Counter outputs 0 to 2 |
| conv_start | output | 1 | Start-of-conversion pulse to the converter |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | 12 | Sample from the converter |
| fifo_rd | input | 1 | Remove the oldest sample |
| fifo_rdata | output | 12 | Oldest stored sample |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties check on every cycle that conv_start never lasts more than one cycle and always comes with busy set. They also check that a disabled buffer or a missing source yields no start, that a clearing write leaves the buffer empty, that a full buffer stays full while nothing is read, and that irq is low while the buffer is disabled. Only the bench scenarios can show which edge polarity and which counter bit each source code responds to. The same holds for the exact readback word, sample ordering through a full wrap, and the silent drop of the sample that arrives when the buffer is full.

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl #(
  parameter int DEPTH    = 4096,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [15:0]         reg_wdata,
  output logic [15:0]         reg_rdata,
  input  logic                sw_start,
  input  logic                ext_trig,
  input  logic [2:0]          cnt_out,
  output logic                conv_start,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_data,
  input  logic                fifo_rd,
  output logic [SAMPLE_W-1:0] fifo_rdata,
  output logic                irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_N = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
  localparam int CLR_BIT = 11;

  logic [2:0] src_sel;
  logic       rng_bip, mode_diff, fifo_en;
  logic [1:0] irq_cond;
  logic       ext_q, busy;
  logic [2:0] cnt_q;
  logic       trig_evt, start_now, src_valid;
  logic       push, pop, empty, full, half;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic       unused_wbits;

  wire wr_clear = reg_wr & reg_wdata[CLR_BIT];
  assign unused_wbits = ^{reg_wdata[15:12], reg_wdata[7:5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel   <= '0;
      rng_bip   <= 1'b0;
      mode_diff <= 1'b0;
      fifo_en   <= 1'b0;
      irq_cond  <= '0;
    end else if (reg_wr) begin
      src_sel   <= reg_wdata[2:0];
      rng_bip   <= reg_wdata[3];
      mode_diff <= reg_wdata[4];
      fifo_en   <= reg_wdata[8];
      irq_cond  <= reg_wdata[10:9];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ext_q <= ext_trig;
      cnt_q <= cnt_out;
    end
  end

  always_comb begin
    case (src_sel)
      3'd1:    trig_evt = sw_start;
      3'd2:    trig_evt = ext_trig & ~ext_q;
      3'd3:    trig_evt = ~ext_trig & ext_q;
      3'd4:    trig_evt = cnt_out[0] & ~cnt_q[0];
      3'd5:    trig_evt = cnt_out[1] & ~cnt_q[1];
      3'd6:    trig_evt = cnt_out[2] & ~cnt_q[2];
      default: trig_evt = 1'b0;
    endcase
  end

  assign src_valid = (src_sel != 3'd0) && (src_sel != 3'd7);
  assign start_now = trig_evt & fifo_en & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      conv_start <= start_now;
      busy       <= (busy & ~conv_done) | start_now;
    end
  end

  assign empty = (count == '0);
  assign full  = (count == FULL_N);
  assign half  = (count >= HALF_N);
  assign push  = conv_done & fifo_en & src_valid & ~full & ~wr_clear;
  assign pop   = fifo_rd & ~empty & ~wr_clear;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= conv_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign fifo_rdata = mem[rd_ptr];

  always_comb begin
    case (irq_cond)
      2'd0:    irq = fifo_en & empty;
      2'd1:    irq = fifo_en & ~empty;
      2'd2:    irq = fifo_en & half;
      default: irq = 1'b0;
    endcase
  end

  assign reg_rdata = {busy, half, full, empty, 1'b0, irq_cond, fifo_en,
                      3'b000, mode_diff, rng_bip, src_sel};

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en || !src_valid) |=> !conv_start);
  p_busy_with_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !fifo_rd && !wr_clear) |=> full);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_N);
  p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> empty);
  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !irq);
endmodule

// File: tb/sim_adc_sample_ctrl.sv
module sim_adc_sample_ctrl;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, sw_start = 1'b0, ext_trig = 1'b0, conv_done = 1'b0, fifo_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0] cnt_out = '0;
  logic [11:0] conv_data = '0;
  logic [11:0] fifo_rdata;
  logic conv_start, irq;

  int checks = 0, errors = 0, starts = 0, cnt_m = 0;
  logic fen_m = 1'b0;
  logic [2:0] sel_m = '0;
  logic [11:0] q[$];

  always #10 clk = ~clk;

  adc_sample_ctrl #(.DEPTH(DEPTH), .SAMPLE_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sw_start(sw_start), .ext_trig(ext_trig),
    .cnt_out(cnt_out), .conv_start(conv_start), .conv_done(conv_done),
    .conv_data(conv_data), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (conv_start) starts++;
    if (fifo_rd && q.size() > 0) begin
      check("R8 order", {20'd0, fifo_rdata}, {20'd0, q.pop_front()});
      cnt_m--;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [15:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    sel_m = v[2:0]; fen_m = v[8];
    if (v[11]) begin q.delete(); cnt_m = 0; end
    step();
    reg_wr = 1'b0;
  endtask

  task automatic conv(input logic [11:0] d);
    conv_done = 1'b1; conv_data = d;
    if (fen_m && sel_m != 3'd0 && sel_m != 3'd7 && cnt_m < DEPTH) begin
      q.push_back(d); cnt_m++;
    end
    step();
    conv_done = 1'b0;
  endtask

  task automatic sw_pulse();
    sw_start = 1'b1; step(); sw_start = 1'b0;
  endtask

  task automatic cnt_pulse(input logic [2:0] v);
    cnt_out = v; step(); cnt_out = '0; step();
  endtask

  task automatic drain();
    int n;
    n = cnt_m;
    for (int i = 0; i < n; i++) begin
      fifo_rd = 1'b1; step();
    end
    fifo_rd = 1'b0;
  endtask

  task automatic expect_starts(input string req, input int s0, input int n);
    step(2);
    check(req, starts - s0, n);
  endtask

  initial begin
    int s0;
    step(3);
    rst_n = 1'b1;
    #1;
    check("R1 readback", reg_rdata, 16'h1000);
    check("R1 irq", irq, 0);
    check("R1 conv_start", conv_start, 0);

    wr(16'h0B19);
    check("R7 readback", reg_rdata, 16'h1319);

    s0 = starts; sw_pulse();
    expect_starts("R2 sw start", s0, 1);
    check("R6 busy set", reg_rdata[15], 1);
    s0 = starts; sw_pulse();
    expect_starts("R6 start ignored while busy", s0, 0);
    conv(12'hABC);
    check("R6 busy cleared", reg_rdata[15], 0);
    check("R11 irq not empty", irq, 1);
    drain();
    check("R9 empty after read", reg_rdata[12], 1);
    check("R11 irq low when empty", irq, 0);

    wr(16'h0102);
    s0 = starts; ext_trig = 1'b1; expect_starts("R3 rising edge", s0, 1);
    conv(12'h111);
    s0 = starts; ext_trig = 1'b0; expect_starts("R3 falling ignored in mode 2", s0, 0);
    wr(16'h0103);
    s0 = starts; ext_trig = 1'b1; expect_starts("R3 rising ignored in mode 3", s0, 0);
    s0 = starts; ext_trig = 1'b0; expect_starts("R3 falling edge", s0, 1);
    conv(12'h222);

    wr(16'h0105);
    s0 = starts; cnt_pulse(3'b001); cnt_pulse(3'b100); expect_starts("R4 other counters ignored", s0, 0);
    s0 = starts; cnt_pulse(3'b010); expect_starts("R4 counter 1", s0, 1);
    conv(12'h333);
    for (int i = 0; i < 3; i += 2) begin
      wr(16'h0100 | 16'(4 + i));
      s0 = starts; cnt_pulse(3'(1 << i)); expect_starts("R4 counter edge", s0, 1);
      conv(12'h440 + 12'(i));
    end
    drain();

    wr(16'h0001);
    s0 = starts; sw_pulse(); expect_starts("R5 disabled no start", s0, 0);
    conv(12'h555);
    check("R5 disabled sample dropped", reg_rdata[12], 1);
    check("R11 irq gated by enable", irq, 0);
    wr(16'h0107);
    s0 = starts; sw_pulse(); expect_starts("R5 source 7 no start", s0, 0);
    conv(12'h556);
    check("R5 source 7 sample dropped", reg_rdata[12], 1);
    wr(16'h0100);
    s0 = starts; sw_pulse(); expect_starts("R5 source 0 no start", s0, 0);

    wr(16'h0501);
    for (int i = 0; i < 7; i++) conv(12'h600 + 12'(i));
    check("R9 below half", reg_rdata[14], 0);
    check("R11 irq half low", irq, 0);
    conv(12'h607);
    check("R9 half flag", reg_rdata[14], 1);
    check("R11 irq half", irq, 1);
    for (int i = 8; i < 16; i++) conv(12'h600 + 12'(i));
    check("R9 full flag", reg_rdata[13], 1);
    conv(12'hFFF);
    check("R9 still full", reg_rdata[13], 1);
    drain();
    check("R9 empty after drain", reg_rdata[15:12], 4'b0001);
    check("R8 all compared", q.size(), 0);

    conv(12'h701); conv(12'h702); conv(12'h703);
    check("R10 filled", reg_rdata[12], 0);
    wr(16'h0901);
    check("R10 cleared", reg_rdata[12], 1);
    check("R10 fields taken", reg_rdata[11:0], 12'h101);
    check("R11 irq on empty", irq, 1);
    wr(16'h0701);
    check("R11 select 3 never", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule